// File: doc/BRIEF.md
# Self-ID packet sequence generator

This block assembles the self-identification packet sequence that a serial-bus PHY transmits for its own node. On a one-cycle start pulse it captures the node parameters and a packed vector of 2-bit port states. These include the PHY identifier, link-active flag, gap count, speed code, contender flag, power class and initiated-reset flag. It then streams the sequence as 32-bit quadlets on a valid/ready interface, and it flags the final quadlet with a last marker.

The first quadlet holds the node parameters and the states of ports 0 to 2. One, two or three extended quadlets follow only when the configured port count needs them. Each extended quadlet carries a sequence number that counts up from zero. Every quadlet except the final one carries a continuation bit. A busy flag stays high from the cycle after the start pulse until the last quadlet has been accepted. Any start pulse seen during that time has no effect.

Top module: `selfid_gen`

## Requirements
- R1: Bits 31:30 of every emitted quadlet are 2'b10, and bits 29:24 hold the 6-bit PHY identifier captured at start.
- R2: In the first quadlet: bit 23 is 0, bit 22 is the link-active flag, bits 21:16 are the gap count, bits 15:14 are the speed code, bit 11 is the contender flag, bits 10:8 are the power class, and bit 1 is the initiated-reset flag. Bits 13:12 are 0.
- R3: In extended quadlet k (k = 1..3, counting from the first quadlet as 0), bit 23 is 1 and bits 22:20 equal k-1. Bits 19:18 and bit 1 are 0.
- R4: Bit 0 is 1 in every quadlet except the final one, where it is 0. out_last is high exactly while the final quadlet is presented.
- R5: The number of quadlets is the smallest q in 1..4 for which 8q-5 is at least port_count. For port_count 1..27 this gives 1 quadlet for 1-3 ports, 2 for 4-11, 3 for 12-19 and 4 for 20-27.
- R6: The 2-bit state of port p (encoding 0 absent, 1 unconnected, 2 to parent, 3 to child) is placed in quadlet (p+5)/8, at bits [s+1:s] where s = 16 - 2*((p+5) mod 8).
- R7: Port slots with index at or above port_count are emitted as 0 regardless of the state presented on port_state.
- R8: While out_valid is high and out_ready is low, out_data, out_last and out_valid stay unchanged in the next cycle.
- R9: busy rises in the cycle after a start pulse accepted while idle and falls in the cycle after the final quadlet is accepted. A start pulse while busy changes neither the running sequence nor the state after it.
- R10: After reset, out_valid and busy are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to emit a sequence |
| phy_id | input | 6 | Node PHY identifier |
| link_active | input | 1 | Link layer active flag |
| gap_count | input | 6 | Gap count value |
| speed_code | input | 2 | Speed capability code |
| contender | input | 1 | Contender flag |
| power_class | input | 3 | Power class |
| init_reset | input | 1 | Node initiated the bus reset |
| port_count | input | 5 | Number of configured ports, 1..27 |
| port_state | input | 54 | 2-bit state per port, port p at [2p+1:2p] |
| out_ready | input | 1 | Downstream accepts the presented quadlet |
| out_valid | output | 1 | A quadlet is presented |
| out_data | output | 32 | Presented quadlet |
| out_last | output | 1 | Presented quadlet is the final one |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions assume that port_count lies in 1..27 when a start pulse arrives, and that start is a single-cycle pulse. Under those conditions the captured count always maps to a valid final index. The bench drives every count from 1 to 27 with start held for exactly one cycle. It fills port slots beyond the count with non-zero states, so that their suppression is visible at the output. It holds the configuration inputs steady around each start, and it varies out_ready among always-high, alternating and one-in-three patterns, issuing an extra start pulse while busy in the last pattern.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

    localparam logic [1:0] SELFID_TAG = 2'b10;

    typedef struct packed {
        logic [5:0] phy_id;
        logic       link_active;
        logic [5:0] gap_count;
        logic [1:0] speed_code;
        logic       contender;
        logic [2:0] power_class;
        logic       init_reset;
    } node_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_t;

endpackage

// File: rtl/selfid_qcount.sv
module selfid_qcount #(
    parameter int QMAX = 4,
    parameter int PCW  = 5,
    parameter int QIW  = 2
) (
    input  logic [PCW-1:0] port_count,
    output logic [QIW-1:0] last_idx
);

    always_comb begin
        last_idx = QIW'(QMAX - 1);
        for (int q = QMAX; q >= 1; q--) begin
            if (int'(port_count) <= 8 * q - 5) begin
                last_idx = QIW'(q - 1);
            end
        end
    end

endmodule

// File: rtl/selfid_assemble.sv
module selfid_assemble
    import selfid_pkg::*;
#(
    parameter int QMAX   = 4,
    parameter int NPORTS = 27,
    parameter int QIW    = 2
) (
    input  node_cfg_t               cfg,
    input  logic [2*NPORTS-1:0]     ports,
    input  logic [QIW-1:0]          idx,
    input  logic [QIW-1:0]          last_idx,
    output logic [31:0]             quadlet
);

    logic [31:0] qw    [QMAX];
    logic [15:0] slots [QMAX];

    for (genvar k = 0; k < QMAX; k++) begin : g_quad
        for (genvar j = 0; j < 8; j++) begin : g_slot
            localparam int P = 8 * k - 5 + j;
            if (P >= 0 && P < NPORTS) begin : g_used
                assign slots[k][15-2*j -: 2] = ports[2*P +: 2];
            end else begin : g_empty
                assign slots[k][15-2*j -: 2] = 2'b00;
            end
        end

        if (k == 0) begin : g_first
            always_comb begin
                qw[k]            = '0;
                qw[k][17:2]      = slots[k];
                qw[k][31:30]     = SELFID_TAG;
                qw[k][29:24]     = cfg.phy_id;
                qw[k][23]        = 1'b0;
                qw[k][22]        = cfg.link_active;
                qw[k][21:16]     = cfg.gap_count;
                qw[k][15:14]     = cfg.speed_code;
                qw[k][11]        = cfg.contender;
                qw[k][10:8]      = cfg.power_class;
                qw[k][1]         = cfg.init_reset;
                qw[k][0]         = (QIW'(k) != last_idx);
            end
        end else begin : g_ext
            always_comb begin
                qw[k]            = '0;
                qw[k][17:2]      = slots[k];
                qw[k][31:30]     = SELFID_TAG;
                qw[k][29:24]     = cfg.phy_id;
                qw[k][23]        = 1'b1;
                qw[k][22:20]     = 3'(k - 1);
                qw[k][0]         = (QIW'(k) != last_idx);
            end
        end
    end

    assign quadlet = qw[idx];

endmodule

// File: rtl/selfid_seq.sv
module selfid_seq
    import selfid_pkg::*;
#(
    parameter int NPORTS = 27,
    parameter int QIW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                out_ready,
    input  node_cfg_t           cfg_in,
    input  logic [2*NPORTS-1:0] ports_in,
    input  logic [QIW-1:0]      last_in,
    output logic                out_valid,
    output logic                out_last,
    output logic                busy,
    output logic [QIW-1:0]      idx,
    output logic [QIW-1:0]      last_idx,
    output node_cfg_t           cfg_q,
    output logic [2*NPORTS-1:0] ports_q
);

    typedef struct packed {
        seq_state_t          st;
        logic [QIW-1:0]      idx;
        logic [QIW-1:0]      last_idx;
        node_cfg_t           cfg;
        logic [2*NPORTS-1:0] ports;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_SEND;
                    r_d.idx      = '0;
                    r_d.last_idx = last_in;
                    r_d.cfg      = cfg_in;
                    r_d.ports    = ports_in;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    if (r_q.idx == r_q.last_idx) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = (r_q.st == ST_SEND);
    assign busy      = out_valid;
    assign out_last  = out_valid && (r_q.idx == r_q.last_idx);
    assign idx       = r_q.idx;
    assign last_idx  = r_q.last_idx;
    assign cfg_q     = r_q.cfg;
    assign ports_q   = r_q.ports;

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> idx <= last_idx); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(out_ready && out_last)) |=> (busy && $stable(cfg_q) && $stable(ports_q))); // R9

    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx))); // R8

endmodule

// File: rtl/selfid_gen.sv
module selfid_gen
    import selfid_pkg::*;
#(
    parameter int QMAX   = 4,
    localparam int NPORTS = 8 * QMAX - 5,
    localparam int PCW    = $clog2(NPORTS + 1),
    localparam int QIW    = (QMAX > 1) ? $clog2(QMAX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [5:0]          phy_id,
    input  logic                link_active,
    input  logic [5:0]          gap_count,
    input  logic [1:0]          speed_code,
    input  logic                contender,
    input  logic [2:0]          power_class,
    input  logic                init_reset,
    input  logic [PCW-1:0]      port_count,
    input  logic [2*NPORTS-1:0] port_state,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [31:0]         out_data,
    output logic                out_last,
    output logic                busy
);

    node_cfg_t           cfg_in;
    node_cfg_t           cfg_q;
    logic [2*NPORTS-1:0] ports_masked;
    logic [2*NPORTS-1:0] ports_q;
    logic [QIW-1:0]      last_in;
    logic [QIW-1:0]      last_idx_q;
    logic [QIW-1:0]      idx_q;

    assign cfg_in = '{phy_id:      phy_id,
                      link_active: link_active,
                      gap_count:   gap_count,
                      speed_code:  speed_code,
                      contender:   contender,
                      power_class: power_class,
                      init_reset:  init_reset};

    for (genvar p = 0; p < NPORTS; p++) begin : g_mask
        assign ports_masked[2*p +: 2] = (PCW'(p) < port_count) ? port_state[2*p +: 2] : 2'b00;
    end

    selfid_qcount #(
        .QMAX (QMAX),
        .PCW  (PCW),
        .QIW  (QIW)
    ) qcount_i (
        .port_count (port_count),
        .last_idx   (last_in)
    );

    selfid_seq #(
        .NPORTS (NPORTS),
        .QIW    (QIW)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .out_ready (out_ready),
        .cfg_in    (cfg_in),
        .ports_in  (ports_masked),
        .last_in   (last_in),
        .out_valid (out_valid),
        .out_last  (out_last),
        .busy      (busy),
        .idx       (idx_q),
        .last_idx  (last_idx_q),
        .cfg_q     (cfg_q),
        .ports_q   (ports_q)
    );

    selfid_assemble #(
        .QMAX   (QMAX),
        .NPORTS (NPORTS),
        .QIW    (QIW)
    ) asm_i (
        .cfg      (cfg_q),
        .ports    (ports_q),
        .idx      (idx_q),
        .last_idx (last_idx_q),
        .quadlet  (out_data)
    );

    AST_HDR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[31:30] == SELFID_TAG)); // R1

    AST_CONT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == !out_data[0])); // R4

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8

    AST_BUSY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !busy); // R9

endmodule

// File: tb/selfid_gen_tb_top.sv
module selfid_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [5:0]  phy_id;
    logic        link_active;
    logic [5:0]  gap_count;
    logic [1:0]  speed_code;
    logic        contender;
    logic [2:0]  power_class;
    logic        init_reset;
    logic [4:0]  port_count;
    logic [53:0] port_state;
    logic        out_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int st_arr [27];

    always #4 clk = ~clk;

    selfid_gen dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .phy_id (phy_id),
        .link_active (link_active), .gap_count (gap_count), .speed_code (speed_code),
        .contender (contender), .power_class (power_class), .init_reset (init_reset),
        .port_count (port_count), .port_state (port_state), .out_ready (out_ready),
        .out_valid (out_valid), .out_data (out_data), .out_last (out_last), .busy (busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expq(input int k, input int n);
        logic [31:0] w;
        int q;
        int sh;
        q = (n + 12) / 8;
        w = '0;
        w[31:30] = 2'b10;
        w[29:24] = phy_id;
        w[0]     = (k < q - 1);
        if (k == 0) begin
            w[22]    = link_active;
            w[21:16] = gap_count;
            w[15:14] = speed_code;
            w[11]    = contender;
            w[10:8]  = power_class;
            w[1]     = init_reset;
        end else begin
            w[23]    = 1'b1;
            w[22:20] = 3'(k - 1);
        end
        for (int p = 0; p < n; p++) begin
            if ((p + 5) / 8 == k) begin
                sh = 16 - 2 * ((p + 5) % 8);
                w[sh +: 2] = 2'(st_arr[p]);
            end
        end
        return w;
    endfunction

    task automatic run_seq(input int n, input int mode);
        int q;
        int got;
        int cyc;
        bit done;
        bit prev_stall;
        logic [31:0] prev_data;
        logic [31:0] e;
        q = (n + 12) / 8;
        phy_id      = 6'((n * 5 + mode) % 64);
        link_active = n[0];
        gap_count   = 6'(63 - n - mode);
        speed_code  = 2'((n + mode) % 4);
        contender   = n[1];
        power_class = 3'((n * 3) % 8);
        init_reset  = ~n[0];
        port_count  = 5'(n);
        for (int p = 0; p < 27; p++) begin
            st_arr[p] = (p * p + 3 * p + n + mode) % 4;
            if (st_arr[p] == 0) st_arr[p] = 1 + (p % 3);
            port_state[2*p +: 2] = 2'(st_arr[p]);
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && out_valid === 1'b1, "R9 busy after start", {30'd0, busy, out_valid}, 32'd3);
        got = 0;
        cyc = 0;
        done = 0;
        prev_stall = 0;
        prev_data = '0;
        while (!done && cyc < 60) begin
            start = (mode == 2 && cyc == 1);
            if (out_valid) begin
                if (prev_stall)
                    chk(out_data === prev_data, "R8 hold under stall", out_data, prev_data);
                case (mode)
                    0: out_ready = 1'b1;
                    1: out_ready = cyc[0];
                    default: out_ready = (cyc % 3 == 2);
                endcase
                if (out_ready) begin
                    e = expq(got, n);
                    chk(out_data[31:24] === e[31:24], "R1 tag and id", {24'd0, out_data[31:24]}, {24'd0, e[31:24]});
                    if (got == 0)
                        chk({out_data[23:14], out_data[13:12], out_data[11:8], out_data[1]} ===
                            {e[23:14], 2'b00, e[11:8], e[1]}, "R2 first fields", out_data, e);
                    else
                        chk({out_data[23:18], out_data[1]} === {e[23:18], 1'b0}, "R3 ext fields", out_data, e);
                    chk(out_data[0] === e[0] && out_last === (got == q - 1), "R4 continuation",
                        {30'd0, out_last, out_data[0]}, {30'd0, (got == q - 1) ? 1'b1 : 1'b0, e[0]});
                    if (got == q - 1 && n < 8 * q - 5)
                        chk(out_data === e, "R7 unused slots zero", out_data, e);
                    else
                        chk(out_data === e, "R6 port placement", out_data, e);
                    if (out_last) done = 1;
                    got++;
                end
                prev_stall = !out_ready;
                prev_data  = out_data;
            end else begin
                out_ready = 1'b0;
                done = 1;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk(got == q, "R5 quadlet count", 32'(got), 32'(q));
        chk(busy === 1'b0 && out_valid === 1'b0, "R9 idle after last", {30'd0, busy, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 start while busy ignored", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected < 150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        out_ready = 1'b0;
        phy_id = '0; link_active = 0; gap_count = '0; speed_code = '0;
        contender = 0; power_class = '0; init_reset = 0;
        port_count = 5'd1; port_state = '0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && busy === 1'b0, "R10 reset state", {30'd0, busy, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && busy === 1'b0, "R10 idle after reset", {30'd0, busy, out_valid}, 32'd0);
        for (int mode = 0; mode < 3; mode++) begin
            for (int n = 1; n <= 27; n++) begin
                run_seq(n, mode);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule